// File: doc/BRIEF.md
# Circular receive frame buffer with descriptor slots

This block holds incoming network frames in a circular byte store and describes each stored frame in a small ring of descriptor slots. A slot records where the frame begins, how many bytes it has, and one status byte built from the frame-good indication and a seven-bit side-band field. The write side takes a byte stream marked with start and end of frame. Frames that cannot be stored are discarded whole. A discarded frame leaves no bytes behind, because the write position falls back to the end of the last stored frame.

The host always sees the oldest stored frame as the current one. Each auto-read strobe returns the byte under the read cursor and moves the cursor forward. A one-cycle end-of-packet pulse follows the read of the final byte, and that frame's slot and bytes are then released. The host can drop the current frame unread, or empty the whole buffer at once. It can also release any set of slots through a mask written to the slot-valid bitmap. A drop flag and a two-bit cause field explain the most recent refusal.

Top module: `rx_ring_buffer`

## Requirements
- R1: Each auto-read strobe (`rd_req`) while a frame is current advances the read cursor by one. Before each strobe, `rd_data` shows the next byte of the current frame, in arrival order.
- R2: A stored frame occupies the next slot of the allocation ring and sets that bit of `valid_map`. `cur_len` reports its byte count.
- R3: `cur_valid` is high whenever any slot is valid. The current-frame outputs always describe the oldest valid slot in arrival order.
- R4: Reading the final byte of the current frame makes `eop` high for exactly the next cycle. The same read clears the frame's `valid_map` bit.
- R5: `skip_req` releases the current frame without reading it. The next frame becomes current with its read cursor at its first byte.
- R6: `clear_all` clears every bit of `valid_map`, `rx_drop` and `fifo_stat` in the next cycle.
- R7: A write with `clr_we` high clears every `valid_map` bit that is set in `clr_mask`, all in the same cycle. If the current frame is among them, the next valid frame becomes current.
- R8: A frame that starts while the allocation slot is still valid is discarded. `rx_drop` is set, `fifo_stat` reads 2'b01, and `valid_map` is unchanged.
- R9: A frame with more bytes than the circular space left is discarded. `rx_drop` is set and `fifo_stat` reads 2'b10. The next stored frame starts where the discarded one started.
- R10: `rx_busy` is high from the cycle after a start byte of a multi-byte frame until the cycle after its end byte.
- R11: `cur_stat` bit 7 holds the frame-good input, and bits 6:0 hold `wr_info[6:0]`. Both are sampled with the end byte.
- R12: Byte addresses wrap modulo the buffer size, so a frame may straddle the end of the store. `cur_addr` gives its start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Incoming byte valid |
| wr_sof | input | 1 | Byte is the first of a frame |
| wr_eof | input | 1 | Byte is the last of a frame |
| wr_good | input | 1 | Frame-good indication, sampled with the last byte |
| wr_data | input | 8 | Incoming byte |
| wr_info | input | 8 | Side-band status, bits 6:0 kept |
| rd_req | input | 1 | Auto-read strobe |
| skip_req | input | 1 | Discard the current frame |
| clear_all | input | 1 | Discard all stored frames |
| clr_we | input | 1 | Apply the slot clear mask |
| clr_mask | input | SLOTS | Slots to release, one bit per slot |
| rd_data | output | 8 | Byte under the read cursor |
| cur_valid | output | 1 | A frame is available |
| cur_addr | output | AW | Start address of the current frame |
| cur_len | output | AW+1 | Byte count of the current frame |
| cur_stat | output | 8 | Status byte of the current frame |
| eop | output | 1 | Final byte of the current frame was read |
| valid_map | output | SLOTS | Valid bit per slot |
| rx_busy | output | 1 | A frame is being received |
| rx_drop | output | 1 | A frame has been discarded |
| fifo_stat | output | 2 | Discard cause: bit 0 no slot, bit 1 no space |

## Verification
The bench builds the block with AW=6 (a 64-byte store) and SLOTS=4. At these values, a sweep over frame lengths 1 to 24 wraps the store several times. Filling every slot takes four short frames. An exact-fit frame that leaves zero free bytes takes only a few dozen bytes. Every start address and byte value is computed arithmetically from running totals and a per-frame seed.

// File: rtl/rx_ring_buffer.sv
module rx_ring_buffer #(
  parameter int AW    = 12,
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_sof,
  input  logic             wr_eof,
  input  logic             wr_good,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       wr_info,
  input  logic             rd_req,
  input  logic             skip_req,
  input  logic             clear_all,
  input  logic             clr_we,
  input  logic [SLOTS-1:0] clr_mask,
  output logic [7:0]       rd_data,
  output logic             cur_valid,
  output logic [AW-1:0]    cur_addr,
  output logic [AW:0]      cur_len,
  output logic [7:0]       cur_stat,
  output logic             eop,
  output logic [SLOTS-1:0] valid_map,
  output logic             rx_busy,
  output logic             rx_drop,
  output logic [1:0]       fifo_stat
);
  localparam int DEPTH = 1 << AW;
  localparam int SW    = $clog2(SLOTS);

  logic [7:0]    mem    [DEPTH];
  logic [AW-1:0] s_addr [SLOTS];
  logic [AW:0]   s_len  [SLOTS];
  logic [7:0]    s_stat [SLOTS];

  logic [SW-1:0] head, tail, cur_idx;
  logic [AW-1:0] wr_base;
  logic [AW:0]   frm_len, rd_off, avail, len_c;
  logic          dropping;

  always_comb begin
    cur_idx = head;
    for (int k = SLOTS - 1; k >= 0; k--)
      if (valid_map[SW'(head + SW'(k))]) cur_idx = SW'(head + SW'(k));
  end

  assign cur_valid = |valid_map;
  assign cur_addr  = s_addr[cur_idx];
  assign cur_len   = s_len[cur_idx];
  assign cur_stat  = s_stat[cur_idx];
  assign rd_data   = mem[AW'(cur_addr + rd_off[AW-1:0])];
  assign avail     = cur_valid ? {1'b0, AW'(cur_addr - wr_base)} : (AW+1)'(DEPTH);

  logic start, cont, slot_full, wr_en, commit, drop_slot, drop_space;
  assign start      = wr_valid & wr_sof;
  assign cont       = wr_valid & ~wr_sof & rx_busy & ~dropping;
  assign slot_full  = valid_map[tail];
  assign drop_slot  = start & slot_full;
  assign drop_space = (start & ~slot_full & (avail == '0)) | (cont & (frm_len >= avail));
  assign wr_en      = (start & ~drop_slot & ~drop_space) | (cont & ~drop_space);
  assign commit     = wr_en & wr_eof;
  assign len_c      = start ? (AW+1)'(1) : frm_len + 1'b1;

  logic rd_fire, last, free_cur;
  logic [SLOTS-1:0] free_mask, valid_n;
  assign rd_fire   = rd_req & cur_valid & ~skip_req & ~clear_all;
  assign last      = rd_fire & (rd_off == cur_len - 1'b1);
  assign free_cur  = (skip_req & cur_valid & ~clear_all) | last;
  assign free_mask = (clr_we ? clr_mask : '0) | (free_cur ? SLOTS'(1) << cur_idx : '0);
  assign valid_n   = (clear_all ? '0 : valid_map & ~free_mask) | (commit ? SLOTS'(1) << tail : '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[AW'(wr_base + (start ? '0 : frm_len[AW-1:0]))] <= wr_data;
    if (commit) begin
      s_addr[tail] <= wr_base;
      s_len[tail]  <= len_c;
      s_stat[tail] <= {wr_good, wr_info[6:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_map <= '0;
      head      <= '0;
      tail      <= '0;
      wr_base   <= '0;
      frm_len   <= '0;
      dropping  <= 1'b0;
      rx_busy   <= 1'b0;
      rd_off    <= '0;
      eop       <= 1'b0;
      rx_drop   <= 1'b0;
      fifo_stat <= '0;
    end else begin
      valid_map <= valid_n;
      eop       <= last;
      if (commit) begin
        tail    <= tail + 1'b1;
        wr_base <= AW'(wr_base + len_c[AW-1:0]);
      end
      head <= clear_all ? tail : (cur_valid ? cur_idx : tail);

      if (start)                     rx_busy <= ~wr_eof;
      else if (wr_valid && wr_eof)   rx_busy <= 1'b0;

      if (start)                     dropping <= drop_slot | drop_space;
      else if (cont && drop_space)   dropping <= 1'b1;

      if (commit || drop_slot || drop_space) frm_len <= '0;
      else if (wr_en)                        frm_len <= len_c;

      if (clear_all || !cur_valid || free_mask[cur_idx]) rd_off <= '0;
      else if (rd_fire)                                  rd_off <= rd_off + 1'b1;

      if (drop_slot || drop_space) begin
        rx_drop   <= 1'b1;
        fifo_stat <= {drop_space, drop_slot};
      end else if (clear_all) begin
        rx_drop   <= 1'b0;
        fifo_stat <= '0;
      end
    end
  end

  p_cursor_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |-> rd_off < cur_len);
  p_one_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valid_map & ~$past(valid_map)));
  p_eop_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> $past(rd_req));
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all && !(wr_valid && wr_eof) |=> valid_map == '0);
  p_busy_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy) |-> $past(wr_valid && (wr_eof || wr_sof)));
endmodule

// File: tb/test_rx_ring_buffer.sv
module test_rx_ring_buffer;
  localparam int AW = 6;
  localparam int SLOTS = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_sof = 0, wr_eof = 0, wr_good = 0;
  logic [7:0] wr_data = 0, wr_info = 0;
  logic rd_req = 0, skip_req = 0, clear_all = 0, clr_we = 0;
  logic [SLOTS-1:0] clr_mask = 0;
  logic [7:0] rd_data, cur_stat;
  logic cur_valid, eop, rx_busy, rx_drop;
  logic [AW-1:0] cur_addr;
  logic [AW:0] cur_len;
  logic [SLOTS-1:0] valid_map;
  logic [1:0] fifo_stat;

  int nvec = 0, nbad = 0, eb = 0;
  bit done = 0;

  rx_ring_buffer #(.AW(AW), .SLOTS(SLOTS)) i_rx_ring_buffer (.*);

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat(int seed, int i);
    return (seed * 7 + i * 13 + 1) & 255;
  endfunction

  task automatic send(int len, int seed, bit good, int info);
    for (int i = 0; i < len; i++) begin
      wr_valid = 1; wr_sof = (i == 0); wr_eof = (i == len - 1);
      wr_data = 8'(pat(seed, i)); wr_good = good; wr_info = 8'(info);
      tick();
      if (i == 0 && len > 1) chk("R10 busy after start", rx_busy, 1);
    end
    wr_valid = 0; wr_sof = 0; wr_eof = 0;
    chk("R10 busy after end", rx_busy, 0);
  endtask

  task automatic consume(int len, int seed, int addr);
    chk("R3 current valid", cur_valid, 1);
    chk("R2 length", cur_len, len);
    chk("R12 start address", cur_addr, addr % DEPTH);
    for (int i = 0; i < len; i++) begin
      chk("R1 read byte", rd_data, pat(seed, i));
      rd_req = 1;
      tick();
      if (i == len - 1) chk("R4 end pulse", eop, 1);
      else chk("R4 no early end", eop, 0);
    end
    rd_req = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R3 reset valid_map", valid_map, 0);
    chk("R3 reset cur_valid", cur_valid, 0);
    chk("R10 reset busy", rx_busy, 0);
    chk("R8 reset drop", rx_drop, 0);
    chk("R8 reset fifo_stat", fifo_stat, 0);

    // R1 R12 R11: length sweep across several wraps
    for (int len = 1; len <= 24; len++) begin
      send(len, len, len[0], len * 5);
      chk("R11 status byte", cur_stat, {len[0], 7'(len * 5)});
      consume(len, len, eb);
      chk("R4 slot freed", valid_map, 0);
      eb += len;
    end

    // R2 R8: fill all slots, then a refused frame
    for (int f = 0; f < 4; f++) send(3, 100 + f, 1, 0);
    chk("R2 all slots valid", valid_map, 4'hF);
    send(5, 99, 1, 0);
    chk("R8 drop flag", rx_drop, 1);
    chk("R8 cause", fifo_stat, 1);
    chk("R8 map unchanged", valid_map, 4'hF);
    consume(3, 100, eb);
    skip_req = 1; tick(); skip_req = 0;
    chk("R5 next after skip", cur_addr, (eb + 6) % DEPTH);
    chk("R5 cursor at start", rd_data, pat(102, 0));
    chk("R5 map after skip", valid_map, 4'hC);
    clear_all = 1; tick(); clear_all = 0;
    chk("R6 map cleared", valid_map, 0);
    chk("R6 drop cleared", rx_drop, 0);
    chk("R6 cause cleared", fifo_stat, 0);
    eb += 12;

    // R9: space exhaustion and roll back
    send(40, 40, 1, 0);
    send(30, 30, 1, 0);
    chk("R9 drop flag", rx_drop, 1);
    chk("R9 cause", fifo_stat, 2);
    chk("R9 map", valid_map, 4'h1);
    send(24, 50, 1, 0);
    chk("R9 exact fit stored", valid_map, 4'h3);
    skip_req = 1; tick(); skip_req = 0;
    consume(24, 50, eb + 40);
    eb += 64;

    // R7: mask clear of several slots at once
    send(2, 60, 1, 0);
    send(2, 61, 1, 0);
    send(2, 62, 1, 0);
    chk("R7 map before", valid_map, 4'hD);
    clr_mask = 4'hC; clr_we = 1; tick(); clr_we = 0; clr_mask = 0;
    chk("R7 map after", valid_map, 4'h1);
    chk("R7 new current", rd_data, pat(62, 0));
    consume(2, 62, eb + 4);
    chk("R7 empty", cur_valid, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule